// File: doc/BRIEF.md
# Iterative Decimal-to-Binary Converter

This block turns a packed decimal value of `DIGITS` four-bit digits into its plain binary equivalent, one result bit per clock. A request loads the digits into a working register whose binary half starts at zero. On each following clock the whole working register moves right by one place: the lowest digit bit drops into the top of the binary half. In the same clock, every digit that now reads 8 or more is reduced by 3. This undoes the add-3 step of the familiar binary-to-decimal shifter.

The number of clocks equals the result width. That width is the count of bits needed to hold the largest decimal value the digits can express, 10^DIGITS − 1. When the last bit has been shifted, the block raises a one-cycle completion pulse and holds the binary value until the next accepted request. Any digit above 9 raises an error flag at load time. The conversion still runs on the raw bits.

Top module: `dec2bin_iter`

## Requirements
- R1: After reset, busy_o, done_o, err_o and every bit of bin_o are 0.
- R2: A start_i high at a rising edge while busy_o is low is accepted. busy_o is high in the following cycle, and bin_o reads 0 in that cycle.
- R3: For a load with no digit above 9, bin_o at completion equals the sum of digit k times 10^k. Digit k occupies bcd_i bits 4k+3 down to 4k, so bits 3:0 hold the least significant decimal digit.
- R4: done_o is high for exactly one cycle. It rises in the cycle that begins RES_W rising edges after the accepting edge, where RES_W is the bit count of 10^DIGITS − 1 (7 for two digits).
- R5: start_i high while busy_o is high has no effect. The running conversion keeps its timing and its result, and the bcd_i value presented with the ignored request is never converted.
- R6: While busy_o is low and no request is accepted, bin_o and err_o hold their values from one cycle to the next.
- R7: err_o is 1 after an accepted load in which any digit is above 9, and 0 after an accepted load in which all digits are 0 to 9. It stays that way until the next accepted load.
- R8: busy_o stays high from the cycle after the accepting edge until the final shift, and it falls in the same cycle that done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| bcd_i | input | 4*DIGITS | Packed decimal operand, least significant digit in bits 3:0 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse: bin_o holds the finished value |
| bin_o | output | RES_W | Binary result |
| err_o | output | 1 | Last accepted operand contained a digit above 9 |

## Verification
A missed correction or a wrong shift is not visible while busy_o is high. It shows up only in the finished value: a digit that is not reduced by 3 puts weight 8 where 5 belongs, and this bends bin_o away from the decimal sum at the completion pulse. An off-by-one in the iteration counter shows at the ports one cycle early or late, as a misplaced done_o and a value that is halved or doubled. A request that leaks in while busy is visible at once, as an early return of bin_o to zero, and later as a completion time or value that matches the intruding operand. Every decimal value from 0 to 99 is converted and compared, and busy_o and done_o are checked against the model on every clock.

// File: rtl/dec2bin_iter.sv
module dec2bin_iter #(
  parameter int DIGITS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [4*DIGITS-1:0]              bcd_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic [res_bits(DIGITS)-1:0]      bin_o,
  output logic                             err_o
);

  function automatic int res_bits(input int n);
    longint top;
    int     b;
    top = 1;
    for (int i = 0; i < n; i++) top = top * 10;
    top = top - 1;
    b = 0;
    for (int i = 0; i < 63; i++) if ((top >> i) != 0) b = i + 1;
    return (b < 1) ? 1 : b;
  endfunction

  localparam int DW    = 4 * DIGITS;
  localparam int RES_W = res_bits(DIGITS);
  localparam int CW    = $clog2(RES_W + 1);
  localparam int TW    = DW + RES_W;

  logic [DW-1:0]    dig_q;
  logic [RES_W-1:0] res_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q, err_q;

  logic [TW-1:0]    shifted;
  logic [DW-1:0]    fixed;
  logic [DIGITS-1:0] bad;
  logic             accept, last;

  assign shifted = {dig_q, res_q} >> 1;
  assign accept  = start_i && !busy_q;
  assign last    = (cnt_q == CW'(RES_W - 1));

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] nib;
    assign nib = shifted[RES_W + 4*g +: 4];
    assign fixed[4*g +: 4] = (nib >= 4'd8) ? nib - 4'd3 : nib;
    assign bad[g] = (bcd_i[4*g +: 4] > 4'd9);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dig_q  <= bcd_i;
        res_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        err_q  <= |bad;
      end else if (busy_q) begin
        dig_q <= fixed;
        res_q <= shifted[RES_W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign bin_o  = res_q;
  assign err_o  = err_q;

  assert_reset_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy_o && !done_o && !err_o && bin_o == '0));

  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && bin_o == '0));

  assert_digits_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (dig_q == '0));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(bin_o) && $stable(err_o)));

  assert_busy_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/dec2bin_iter_tb_top.sv
`timescale 1ns/1ps
module dec2bin_iter_tb_top;
  localparam int D  = 2;
  localparam int DW = 4 * D;
  localparam int BW = 7;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [DW-1:0] bcd_i = '0;
  logic busy_o, done_o, err_o;
  logic [BW-1:0] bin_o;

  int checks = 0, errors = 0;

  dec2bin_iter #(.DIGITS(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bcd_i(bcd_i),
    .busy_o(busy_o), .done_o(done_o), .bin_o(bin_o), .err_o(err_o));

  always #10 clk = ~clk;

  int  m_busy = 0, m_done = 0, m_cnt = 0, m_err = 0, m_val = 0, m_bin = 0, m_fresh = 0;
  bit  m_known = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec_of(input logic [DW-1:0] v, output int bad);
    int s = 0, w = 1;
    bad = 0;
    for (int k = 0; k < D; k++) begin
      if (v[4*k +: 4] > 9) bad = 1;
      s += int'(v[4*k +: 4]) * w;
      w *= 10;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    int b;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_err = 0; m_bin = 0; m_known = 1; m_fresh = 0;
    end else begin
      m_done = 0; m_fresh = 0;
      if (m_busy == 0 && start_i) begin
        m_val = dec_of(bcd_i, b);
        m_err = b; m_busy = 1; m_cnt = 0; m_bin = 0; m_known = 0; m_fresh = 1;
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == BW) begin
          m_busy = 0; m_done = 1; m_bin = m_val; m_known = (m_err == 0);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy_o == m_busy, "R8 busy", busy_o, m_busy);
      check(done_o == m_done, "R4 done", done_o, m_done);
      if (!m_busy) check(err_o == m_err, "R7 err", err_o, m_err);
      if (m_fresh) check(bin_o == 0, "R2 cleared", bin_o, 0);
      if (!m_busy && m_known) check(bin_o == m_bin, "R3/R6 value", bin_o, m_bin);
    end
  end

  task automatic convert(input logic [DW-1:0] v);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    bcd_i = v; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0 && err_o == 0 && bin_o == 0, "R1 reset", bin_o, 0);
    convert(8'h24);
    check(bin_o == 24, "R3 24", bin_o, 24);
    convert(8'h96);
    check(bin_o == 96, "R3 96", bin_o, 96);
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) convert({4'(t), 4'(u)});
    convert(8'h99);
    check(bin_o == 99, "R3 99", bin_o, 99);
    // R5: request during conversion is ignored
    @(negedge clk);
    bcd_i = 8'h37; start_i = 1;
    @(negedge clk);
    bcd_i = 8'h81;
    repeat (3) @(negedge clk);
    start_i = 0;
    while (!done_o) @(negedge clk);
    check(bin_o == 37, "R5 ignored", bin_o, 37);
    // R6: hold while idle
    repeat (5) @(negedge clk);
    check(bin_o == 37 && err_o == 0, "R6 hold", bin_o, 37);
    // R7: bad digit
    convert(8'hA5);
    check(err_o == 1, "R7 set", err_o, 1);
    repeat (3) @(negedge clk);
    check(err_o == 1, "R7 held", err_o, 1);
    convert(8'h3F);
    check(err_o == 1, "R7 low nibble", err_o, 1);
    convert(8'h50);
    check(err_o == 0 && bin_o == 50, "R7 clear", bin_o, 50);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule